// File: doc/BRIEF.md
# Command-Driven I2C Byte Master

This block is a single-master I2C engine that moves exactly one byte per command. Software writes a five-bit command word whose bits ask for any mix of a START condition, one byte write (taken from `tx_data`) or one byte read (left in `rx_data`), a not-acknowledge on the read, and a STOP condition. The engine pulls SCL and SDA low through output-enable pins (open-drain style) and reads the SDA level back through `sda_in`. When the command is done it raises `op_over`. It also reports a missing acknowledge, a lost arbitration, and whether the bus is currently owned.

Addressing is 7-bit only. Software sends the address byte, with the R/W bit in its LSB, as a START+WRITE command. It then issues WRITE or READ commands byte by byte. On the last read byte it sets NO_ACK, and it ends the transfer with STOP. Two count inputs set the SCL high and low times. The engine never stretches SCL and never waits on it.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, `scl_oe` and `sda_oe` are 0, `cmd_ready` is 1, and `op_over`, `ack_err`, `arb_lost` and `bus_busy` are 0.
- R2: The command word bit positions are: bit 4 NO_ACK, bit 3 START, bit 2 READ, bit 1 WRITE, bit 0 STOP. With START set, SDA falls while SCL is high before any data bit, and `bus_busy` rises.
- R3: A WRITE sends `tx_data` MSB first, one bit per SCL high phase, then releases SDA for a ninth clock. A low level there leaves `ack_err` at 0.
- R4: A READ shifts eight SDA samples, MSB first, into `rx_data`. On the ninth clock the engine drives SDA low, or leaves it high when NO_ACK is set.
- R5: A high SDA level on the ninth clock of a WRITE sets `ack_err`.
- R6: Every finished command sets `op_over` and returns `cmd_ready` to 1. This includes a command with no bits set and a STOP-only command. Accepting a new command clears `op_over`, `ack_err` and `arb_lost`.
- R7: If SDA reads low while the engine releases it during a written data bit, or during the START setup, `arb_lost` is set. The command then ends after that bit, and no further SCL pulses occur.
- R8: After `ack_err` or `arb_lost`, a STOP requested in the same command is not performed. SCL stays held low and SDA is released.
- R9: A STOP makes SDA rise while SCL is high. Afterwards both lines are released and `bus_busy` is 0.
- R10: Outside START and STOP conditions, SDA never changes while SCL is high. A command without START or STOP produces neither condition.
- R11: Each SCL high phase of a data bit lasts 2·(`scl_hi_cnt`+1) clock cycles. Each low phase lasts 2·(`scl_lo_cnt`+1) clock cycles.
- R12: A START issued while SCL is held low after a byte produces a fresh START condition (repeated start).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when `cmd_ready` is 1 |
| cmd | input | 5 | Command bits: NO_ACK, START, READ, WRITE, STOP (bit 4 down to 0) |
| tx_data | input | DW | Byte sent by a WRITE, latched at acceptance |
| scl_hi_cnt | input | CW | SCL high count N, phase = 2·(N+1) cycles |
| scl_lo_cnt | input | CW | SCL low count N, phase = 2·(N+1) cycles |
| cmd_ready | output | 1 | Engine idle, a command may be issued |
| rx_data | output | DW | Last byte received by a READ |
| op_over | output | 1 | Last command has finished |
| ack_err | output | 1 | Written byte was not acknowledged |
| arb_lost | output | 1 | Released SDA was seen low |
| bus_busy | output | 1 | Bus owned, from START until STOP completes |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The assertions check on every cycle that:
- SDA holds steady through each data-bit high phase.
- The phase counter and the bit index stay in range.
- `op_over` is seen only while idle.
- The two error flags never both appear.
- No STOP begins after an error.
- `bus_busy` drops only once both lines are released.

What the assertions cannot show is left to the bench scenarios: the bit order on the wire, the acknowledge level for reads with and without NO_ACK, the repeated START, the bit at which arbitration aborts, and the SCL phase lengths across a sweep of high and low counts. The bench drives these through a small slave model and checks them against values it computes itself.

// File: rtl/i2c_cmd_pkg.sv
// Shared definitions for the command-driven I2C master.
// Assumes: command word is five bits with fixed positions decoded by software.
package i2c_cmd_pkg;
    localparam int CMD_W     = 5;
    localparam int BIT_NACK  = 4;
    localparam int BIT_START = 3;
    localparam int BIT_READ  = 2;
    localparam int BIT_WRITE = 1;
    localparam int BIT_STOP  = 0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RS_LO,   // SCL low before a repeated START
        ST_SU,      // START setup: both lines released
        ST_HD,      // START hold: SDA low, SCL high
        ST_BIT_LO,  // data bit, SCL low
        ST_BIT_HI,  // data bit, SCL high
        ST_REL,     // SCL low, release SDA, finish
        ST_SP_LO,   // STOP: SCL low, pull SDA
        ST_SP_SU,   // STOP: SCL high, SDA low
        ST_SP_HD    // STOP: both released
    } mst_state_t;
endpackage

// File: rtl/i2c_phase_timer.sv
// Times one SCL phase of 2*(N+1) cycles, N taken from the high or low count.
// Pulses mid at the phase centre and last on its final cycle.
// Assumes: counts stay stable while a phase runs.
module i2c_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          sel_hi,
    input  logic [CW-1:0] hi_cnt,
    input  logic [CW-1:0] lo_cnt,
    output logic          mid,
    output logic          last
);
    logic [CW:0]   cnt_q;
    logic [CW-1:0] n_sel;
    logic [CW:0]   limit;

    // select the active count and derive the phase end
    always_comb begin
        n_sel = sel_hi ? hi_cnt : lo_cnt;
        limit = {n_sel, 1'b1};
        mid   = run && (cnt_q == {1'b0, n_sel});
        last  = run && (cnt_q == limit);
    end

    // count cycles within the phase, restart on each phase end
    always_ff @(posedge clk) begin
        if (!rst_n || !run || last) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= limit));
endmodule

// File: rtl/i2c_byte_shifter.sv
// Transmit and receive shift registers plus the bit index of the current byte.
// Assumes: load and step are never asserted in the same cycle.
module i2c_byte_shifter #(
    parameter int DW = 8,
    localparam int IW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] tx_data,
    input  logic          sample_en,
    input  logic          sample_bit,
    input  logic          step,
    output logic          tx_msb,
    output logic [DW-1:0] rx_shift,
    output logic          last_bit
);
    logic [DW-1:0] tx_q;
    logic [IW-1:0] idx_q;

    // outgoing byte, moved left one bit per step
    always_ff @(posedge clk) begin
        if (!rst_n)    tx_q <= '0;
        else if (load) tx_q <= tx_data;
        else if (step) tx_q <= {tx_q[DW-2:0], 1'b0};
    end

    // bit index, DW marks the acknowledge slot
    always_ff @(posedge clk) begin
        if (!rst_n)    idx_q <= '0;
        else if (load) idx_q <= '0;
        else if (step) idx_q <= idx_q + 1'b1;
    end

    // incoming byte, MSB arrives first
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_shift <= '0;
        else if (sample_en) rx_shift <= {rx_shift[DW-2:0], sample_bit};
    end

    assign tx_msb   = tx_q[DW-1];
    assign last_bit = (idx_q == IW'(DW));

    p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IW'(DW));
endmodule

// File: rtl/i2c_cmd_master.sv
// One-byte-per-command I2C master: optional START, a write or read byte with
// acknowledge, optional STOP. Drives open-drain lines through output enables.
// Assumes: single master, no clock stretching, counts stable during a command.
module i2c_cmd_master
    import i2c_cmd_pkg::*;
#(
    parameter int CW = 8,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd,
    input  logic [DW-1:0]    tx_data,
    input  logic [CW-1:0]    scl_hi_cnt,
    input  logic [CW-1:0]    scl_lo_cnt,
    output logic             cmd_ready,
    output logic [DW-1:0]    rx_data,
    output logic             op_over,
    output logic             ack_err,
    output logic             arb_lost,
    output logic             bus_busy,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe
);
    mst_state_t    state_q;
    logic          q_rd, q_wr, q_nack, q_stop;
    logic          sda_q, held_q;
    logic          run, sel_hi, mid, last;
    logic          tx_msb, last_bit, drv_bit;
    logic          accept, step, sample_en;
    logic [DW-1:0] rx_shift;

    // phase decode: which states time a high phase, where SCL is pulled
    always_comb begin
        run     = (state_q != ST_IDLE);
        sel_hi  = (state_q == ST_SU) || (state_q == ST_HD) ||
                  (state_q == ST_BIT_HI) || (state_q == ST_SP_SU) ||
                  (state_q == ST_SP_HD);
        accept  = cmd_valid && (state_q == ST_IDLE);
        step    = (state_q == ST_BIT_HI) && last && !last_bit;
        sample_en = (state_q == ST_BIT_HI) && mid && !last_bit && q_rd;
        drv_bit = last_bit ? (q_rd && !q_nack) : (!q_rd && !tx_msb);
    end

    i2c_phase_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .sel_hi(sel_hi),
        .hi_cnt(scl_hi_cnt), .lo_cnt(scl_lo_cnt), .mid(mid), .last(last)
    );

    i2c_byte_shifter #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(accept), .tx_data(tx_data),
        .sample_en(sample_en), .sample_bit(sda_in), .step(step),
        .tx_msb(tx_msb), .rx_shift(rx_shift), .last_bit(last_bit)
    );

    // command sequencer: conditions, bits, acknowledge and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            {q_rd, q_wr, q_nack, q_stop} <= '0;
            sda_q <= 1'b0; held_q <= 1'b0; bus_busy <= 1'b0;
            op_over <= 1'b0; ack_err <= 1'b0; arb_lost <= 1'b0;
            rx_data <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (cmd_valid) begin
                    q_rd   <= cmd[BIT_READ];
                    q_wr   <= cmd[BIT_WRITE];
                    q_nack <= cmd[BIT_NACK];
                    q_stop <= cmd[BIT_STOP];
                    op_over <= 1'b0; ack_err <= 1'b0; arb_lost <= 1'b0;
                    if (cmd[BIT_START])
                        state_q <= held_q ? ST_RS_LO : ST_SU;
                    else if (cmd[BIT_READ] || cmd[BIT_WRITE])
                        state_q <= ST_BIT_LO;
                    else if (cmd[BIT_STOP])
                        state_q <= ST_SP_LO;
                    else
                        op_over <= 1'b1;
                end
                ST_RS_LO: begin
                    if (mid)  sda_q   <= 1'b0;
                    if (last) state_q <= ST_SU;
                end
                ST_SU: begin
                    if (mid && !sda_in) arb_lost <= 1'b1;
                    if (last) begin
                        if (arb_lost) state_q <= ST_REL;
                        else begin
                            sda_q <= 1'b1; bus_busy <= 1'b1; state_q <= ST_HD;
                        end
                    end
                end
                ST_HD: if (last) state_q <= (q_rd || q_wr) ? ST_BIT_LO : ST_REL;
                ST_BIT_LO: begin
                    if (mid)  sda_q   <= drv_bit;
                    if (last) state_q <= ST_BIT_HI;
                end
                ST_BIT_HI: begin
                    if (mid) begin
                        if (last_bit && !q_rd && sda_in) ack_err <= 1'b1;
                        if (!last_bit && !q_rd && !sda_q && !sda_in) arb_lost <= 1'b1;
                    end
                    if (last) begin
                        if (ack_err || arb_lost) state_q <= ST_REL;
                        else if (last_bit) begin
                            if (q_rd) rx_data <= rx_shift;
                            state_q <= q_stop ? ST_SP_LO : ST_REL;
                        end else state_q <= ST_BIT_LO;
                    end
                end
                ST_REL: begin
                    if (mid) sda_q <= 1'b0;
                    if (last) begin
                        state_q <= ST_IDLE; held_q <= 1'b1; op_over <= 1'b1;
                    end
                end
                ST_SP_LO: begin
                    if (mid)  sda_q   <= 1'b1;
                    if (last) state_q <= ST_SP_SU;
                end
                ST_SP_SU: if (last) begin
                    sda_q <= 1'b0; state_q <= ST_SP_HD;
                end
                ST_SP_HD: if (last) begin
                    state_q <= ST_IDLE; held_q <= 1'b0;
                    bus_busy <= 1'b0; op_over <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cmd_ready = (state_q == ST_IDLE);
    assign scl_oe    = run ? !sel_hi : held_q;
    assign sda_oe    = sda_q;

    p_over_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_over |-> cmd_ready);
    p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_err, arb_lost}));
    p_no_stop_after_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SP_LO) |-> !(ack_err || arb_lost));
    p_busy_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_busy) |-> (!scl_oe && !sda_oe));
    p_sda_quiet_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BIT_HI && $past(state_q == ST_BIT_HI)) |-> $stable(sda_oe));
endmodule

// File: tb/i2c_cmd_master_bench.sv
// Bench: slave model on the lines, sweeps of bytes and phase counts.
module i2c_cmd_master_bench;
    localparam int CW = 8;
    localparam int DW = 8;
    localparam logic [4:0] C_NACK = 5'd16, C_START = 5'd8, C_READ = 5'd4,
                           C_WRITE = 5'd2, C_STOP = 5'd1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [4:0] cmd = '0;
    logic [DW-1:0] tx_data = '0;
    logic [CW-1:0] hi_cnt = 8'd1, lo_cnt = 8'd1;
    logic cmd_ready, op_over, ack_err, arb_lost, bus_busy, scl_oe, sda_oe, sda_in;
    logic [DW-1:0] rx_data;

    // slave model state
    logic pull = 1'b0, arb_force = 1'b0, rd_mode = 1'b0, ack_en = 1'b1;
    logic [7:0] rbyte = '0, cap = '0;
    logic ack_bit = 1'b1, prev_scl = 1'b1, prev_sda = 1'b1;
    int rise_cnt = 0, start_cnt = 0, stop_cnt = 0, run_len = 0, hi_len = 0, lo_len = 0;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    assign sda_in = ~(sda_oe | pull | arb_force);

    i2c_cmd_master #(.CW(CW), .DW(DW)) u_i2c_cmd_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .tx_data(tx_data), .scl_hi_cnt(hi_cnt), .scl_lo_cnt(lo_cnt),
        .cmd_ready(cmd_ready), .rx_data(rx_data), .op_over(op_over),
        .ack_err(ack_err), .arb_lost(arb_lost), .bus_busy(bus_busy),
        .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // line watcher and slave responder, evaluated between clock edges
    always @(negedge clk) begin
        logic scl, sda;
        scl = ~scl_oe;
        sda = sda_in;
        if (cmd_valid) begin
            rise_cnt = 0;
            pull = rd_mode ? ~rbyte[7] : 1'b0;
        end
        if (prev_scl && scl && prev_sda && !sda) begin start_cnt++; rise_cnt = 0; end
        if (prev_scl && scl && !prev_sda && sda) stop_cnt++;
        if (!prev_scl && scl) begin
            if (rise_cnt < 8) cap = {cap[6:0], sda};
            else if (rise_cnt == 8) ack_bit = sda;
            rise_cnt++;
        end
        if (prev_scl && !scl) begin
            if (rise_cnt < 8)       pull = rd_mode ? ~rbyte[7-rise_cnt] : 1'b0;
            else if (rise_cnt == 8) pull = rd_mode ? 1'b0 : ack_en;
            else                    pull = 1'b0;
        end
        if (scl == prev_scl) run_len++;
        else begin
            if (prev_scl) hi_len = run_len; else lo_len = run_len;
            run_len = 1;
        end
        prev_scl = scl;
        prev_sda = sda;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [4:0] c, input logic [7:0] d);
        @(posedge clk); #2;
        cmd = c; tx_data = d; cmd_valid = 1'b1;
        @(posedge clk); #2;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_over();
        int k;
        for (k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (op_over) break;
        end
        if (k == 20000) check("R6 timeout", 0, 1);
    endtask

    task automatic do_cmd(input logic [4:0] c, input logic [7:0] d);
        issue(c, d);
        wait_over();
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int s0, p0;
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 scl_oe", scl_oe, 0);
        check("R1 sda_oe", sda_oe, 0);
        check("R1 ready", cmd_ready, 1);
        check("R1 flags", {op_over, ack_err, arb_lost, bus_busy}, 0);

        // R2 START+WRITE address
        s0 = start_cnt;
        do_cmd(C_START | C_WRITE, 8'hA4);
        check("R2 start seen", start_cnt, s0 + 1);
        check("R2 byte", cap, 8'hA4);
        check("R2 busy", bus_busy, 1);
        check("R3 ack ok", ack_err, 0);
        check("R6 over", op_over, 1);

        // R3 / R10 write sweep without conditions
        for (int i = 0; i < 16; i++) begin
            s0 = start_cnt; p0 = stop_cnt;
            do_cmd(C_WRITE, 8'(i * 17 + (i & 1)));
            check("R3 byte", cap, (i * 17 + (i & 1)) & 255);
            check("R3 ack_err", ack_err, 0);
            check("R10 no cond", start_cnt - s0 + stop_cnt - p0, 0);
        end

        // R5 missing acknowledge
        ack_en = 1'b0;
        do_cmd(C_WRITE, 8'h3C);
        check("R5 ack_err", ack_err, 1);
        check("R5 ack level", ack_bit, 1);
        ack_en = 1'b1;

        // R6 flags cleared at acceptance
        issue(C_WRITE, 8'h11);
        @(negedge clk);
        check("R6 clear ack_err", ack_err, 0);
        check("R6 clear over", op_over, 0);
        wait_over(); @(negedge clk);

        // R8 STOP skipped after NACK
        ack_en = 1'b0; p0 = stop_cnt;
        do_cmd(C_WRITE | C_STOP, 8'h42);
        check("R8 ack_err", ack_err, 1);
        check("R8 no stop", stop_cnt, p0);
        check("R8 scl held", scl_oe, 1);
        check("R8 sda free", sda_oe, 0);
        ack_en = 1'b1;

        // R12 repeated start
        s0 = start_cnt;
        do_cmd(C_START | C_WRITE, 8'hA5);
        check("R12 restart", start_cnt, s0 + 1);

        // R4 read sweep with ACK
        rd_mode = 1'b1;
        for (int i = 0; i < 8; i++) begin
            rbyte = 8'(i * 23 + 1 + (i << 5));
            do_cmd(C_READ, 8'h00);
            check("R4 rx", rx_data, rbyte);
            check("R4 master ack", ack_bit, 0);
        end

        // R4 / R9 last byte NACK then STOP
        rbyte = 8'h5A; p0 = stop_cnt;
        do_cmd(C_READ | C_NACK | C_STOP, 8'h00);
        rd_mode = 1'b0;
        check("R4 rx last", rx_data, 8'h5A);
        check("R4 nack level", ack_bit, 1);
        check("R9 stop seen", stop_cnt, p0 + 1);
        check("R9 busy low", bus_busy, 0);
        check("R9 lines free", {scl_oe, sda_oe}, 0);

        // R6 empty command
        do_cmd(5'd0, 8'h00);
        check("R6 empty over", op_over, 1);

        // R11 phase length sweep
        for (int h = 0; h < 4; h++) begin
            for (int l = 0; l < 4; l++) begin
                hi_cnt = 8'(h); lo_cnt = 8'(l);
                do_cmd(C_START | C_WRITE | C_STOP, 8'(16 * h + l + 3));
                check("R11 high len", hi_len, 2 * (h + 1));
                check("R11 low len", lo_len, 2 * (l + 1));
                check("R11 byte", cap, (16 * h + l + 3) & 255);
            end
        end
        hi_cnt = 8'd1; lo_cnt = 8'd1;

        // R7 / R8 arbitration loss on a written 1
        do_cmd(C_START | C_WRITE, 8'h20);
        arb_force = 1'b1; p0 = stop_cnt;
        do_cmd(C_WRITE | C_STOP, 8'hFF);
        arb_force = 1'b0;
        check("R7 arb_lost", arb_lost, 1);
        check("R7 ack_err", ack_err, 0);
        check("R7 bits clocked", rise_cnt, 1);
        check("R8 no stop arb", stop_cnt, p0);
        check("R8 scl held arb", scl_oe, 1);

        // R9 release the bus
        p0 = stop_cnt;
        do_cmd(C_STOP, 8'h00);
        check("R9 stop only", stop_cnt, p0 + 1);
        check("R9 busy end", bus_busy, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule